// File: doc/BRIEF.md
# Data memory with mapped screen and keyboard

This block is the data-side memory of a small 16-bit processor. One word address space is split three ways: ordinary read/write RAM at the bottom, then a monochrome frame buffer, then a single word that reports the code of the key being held. The CPU presents an address, write data and a write strobe. The read word comes back combinationally, and a write commits on the rising clock edge. Because the read is combinational, one instruction can read a word, change it and write it back in the same cycle.

A second, independent read port serves a display scanner. The scanner gives a row and a word column and gets that frame-buffer word back, registered one cycle later. Each screen word holds 16 horizontally adjacent pixels. Bit 0 is the leftmost pixel of the group, and a 1 is a black pixel. Addresses above the key word are unused: reads there return zero and writes there are dropped.

The sizes are parameters. `RAM_AW` sets RAM to 2^RAM_AW words and `SCR_AW` sets the frame buffer to 2^SCR_AW words (SCR_AW < RAM_AW). The address is RAM_AW+1 bits wide. The full system uses RAM_AW=14 and SCR_AW=13, which gives RAM at 0..16383, the screen at 16384..24575 (256 rows of 32 words, so 512x256 pixels) and the key word at 24576, in a 32K-word space. The defaults are RAM_AW=9 and SCR_AW=8: RAM at 0..511, the screen at 512..767 (8 rows of 32 words), the key word at 768, and the unused range 769..1023.

Top module: `data_mem_map`

## Requirements
- R1: A write to a RAM address (below 2^RAM_AW) commits on the rising edge. Afterwards `cpu_rdata` returns that word whenever `cpu_addr` selects it, combinationally in the same cycle.
- R2: A write to a screen address (2^RAM_AW up to KEY-1) is stored and read back the same way on the CPU port.
- R3: With `cpu_addr` equal to the key address KEY = 2^RAM_AW + 2^SCR_AW, `cpu_rdata` equals `key_code` in the same cycle, and it follows `key_code` when that input changes. It reads zero when no key is held (`key_code` = 0).
- R4: Writes to KEY and to any address above it change no stored word, and a read of KEY still returns `key_code`.
- R5: Any read of an address above KEY returns 0.
- R6: During a write cycle, `cpu_rdata` still shows the old word at that address. After the edge it shows the written word, so a read-modify-write completes in one cycle.
- R7: `scan_data` returns the frame-buffer word at screen offset {scan_row, scan_col} (row × ROW_WORDS + col), one clock after the coordinates are presented.
- R8: When the CPU writes the word the scanner is reading, the edge of the write still delivers the old word on `scan_data`. The new word appears after the following edge.
- R9: While `rst` is high at a rising edge, `scan_data` is cleared to 0.
- R10: The RAM and screen regions do not alias: a RAM word and the screen word with the same low address bits keep independent contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and the scan register update on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the scan output register |
| cpu_addr | input | RAM_AW+1 | CPU word address |
| cpu_wdata | input | DATA_W | CPU write data |
| cpu_we | input | 1 | CPU write strobe |
| cpu_rdata | output | DATA_W | Combinational read data for `cpu_addr` |
| key_code | input | DATA_W | Code of the currently held key, 0 when none |
| scan_row | input | SCR_AW-log2(ROW_WORDS) | Scanner row |
| scan_col | input | log2(ROW_WORDS) | Scanner word column within the row |
| scan_data | output | DATA_W | Registered frame-buffer word for the scanner |

## Verification
The case that is hardest to reach from the ports is the collision between a CPU write and a scanner read of the same frame-buffer word. The CPU address, the write strobe and the scan coordinates all have to line up on one edge, and the old and new words then show up on two consecutive edges. The bench aims the scanner at a word whose contents it already knows, writes a distinct value to that word through the CPU port on the same edge, and samples `scan_data` after each of the next two edges. Aliasing is exposed by filling the whole address space with a bijective pattern before any read. That sweep includes the key word and the unused range, so a dropped write that had landed anywhere would show up in the readback.

// File: rtl/dmm_pkg.sv
package dmm_pkg;

  typedef enum logic [1:0] {
    RGN_RAM  = 2'd0,
    RGN_SCR  = 2'd1,
    RGN_KEY  = 2'd2,
    RGN_NONE = 2'd3
  } region_t;

endpackage

// File: rtl/dmm_decode.sv
module dmm_decode
  import dmm_pkg::*;
#(
  parameter int RAM_AW = 9,
  parameter int SCR_AW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RAM_AW:0]   addr,
  input  logic              we,
  output region_t           region,
  output logic              ram_we,
  output logic              scr_we,
  output logic [RAM_AW-1:0] ram_idx,
  output logic [SCR_AW-1:0] scr_idx
);

  localparam int AW = RAM_AW + 1;
  localparam logic [AW-1:0] SCR_BASE = AW'(2 ** RAM_AW);
  localparam logic [AW-1:0] KEY_ADDR = AW'(2 ** RAM_AW + 2 ** SCR_AW);

  always_comb begin
    if (addr < SCR_BASE)       region = RGN_RAM;
    else if (addr < KEY_ADDR)  region = RGN_SCR;
    else if (addr == KEY_ADDR) region = RGN_KEY;
    else                       region = RGN_NONE;
  end

  assign ram_we  = we && (region == RGN_RAM);
  assign scr_we  = we && (region == RGN_SCR);
  assign ram_idx = addr[RAM_AW-1:0];
  assign scr_idx = addr[SCR_AW-1:0];

  AST_KEY_WRITE_DROP: assert property (@(posedge clk) disable iff (rst)
    (addr >= KEY_ADDR) |-> (!ram_we && !scr_we)); // R4

  AST_ONE_STORE_WRITTEN: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ram_we, scr_we})); // R10

endmodule

// File: rtl/dmm_word_store.sv
module dmm_word_store #(
  parameter int AW       = 9,
  parameter int DATA_W   = 16,
  parameter bit HAS_SCAN = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata,
  input  logic [AW-1:0]     scan_addr,
  output logic [DATA_W-1:0] scan_q
);

  localparam int DEPTH = 2 ** AW;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

  generate
    if (HAS_SCAN) begin : g_scan
      logic [DATA_W-1:0] scan_r;
      always_ff @(posedge clk) begin
        if (rst) scan_r <= '0;
        else     scan_r <= mem[scan_addr];
      end
      assign scan_q = scan_r;

      always @(posedge clk) begin
        if (!rst && $past(rst))
          AST_SCAN_CLEARED: assert (scan_q == '0); // R9
      end
    end else begin : g_no_scan
      logic unused_scan;
      assign unused_scan = rst ^ (^scan_addr);
      assign scan_q = '0;
    end
  endgenerate

endmodule

// File: rtl/data_mem_map.sv
module data_mem_map
  import dmm_pkg::*;
#(
  parameter int RAM_AW    = 9,
  parameter int SCR_AW    = 8,
  parameter int ROW_WORDS = 32,
  parameter int DATA_W    = 16
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic [RAM_AW:0]                      cpu_addr,
  input  logic [DATA_W-1:0]                    cpu_wdata,
  input  logic                                 cpu_we,
  output logic [DATA_W-1:0]                    cpu_rdata,
  input  logic [DATA_W-1:0]                    key_code,
  input  logic [SCR_AW-$clog2(ROW_WORDS)-1:0]  scan_row,
  input  logic [$clog2(ROW_WORDS)-1:0]         scan_col,
  output logic [DATA_W-1:0]                    scan_data
);

  localparam int AW    = RAM_AW + 1;
  localparam int COL_W = $clog2(ROW_WORDS);
  localparam logic [AW-1:0] KEY_ADDR = AW'(2 ** RAM_AW + 2 ** SCR_AW);

  region_t           region;
  logic              ram_we, scr_we;
  logic [RAM_AW-1:0] ram_idx;
  logic [SCR_AW-1:0] scr_idx;
  logic [DATA_W-1:0] ram_rd, scr_rd, ram_scan_unused;
  logic [SCR_AW-1:0] scan_idx;

  assign scan_idx = {scan_row, scan_col};

  dmm_decode #(.RAM_AW(RAM_AW), .SCR_AW(SCR_AW)) u_decode (
    .clk     (clk),
    .rst     (rst),
    .addr    (cpu_addr),
    .we      (cpu_we),
    .region  (region),
    .ram_we  (ram_we),
    .scr_we  (scr_we),
    .ram_idx (ram_idx),
    .scr_idx (scr_idx)
  );

  dmm_word_store #(.AW(RAM_AW), .DATA_W(DATA_W), .HAS_SCAN(1'b0)) u_ram (
    .clk       (clk),
    .rst       (rst),
    .we        (ram_we),
    .waddr     (ram_idx),
    .wdata     (cpu_wdata),
    .raddr     (ram_idx),
    .rdata     (ram_rd),
    .scan_addr ('0),
    .scan_q    (ram_scan_unused)
  );

  dmm_word_store #(.AW(SCR_AW), .DATA_W(DATA_W), .HAS_SCAN(1'b1)) u_screen (
    .clk       (clk),
    .rst       (rst),
    .we        (scr_we),
    .waddr     (scr_idx),
    .wdata     (cpu_wdata),
    .raddr     (scr_idx),
    .rdata     (scr_rd),
    .scan_addr (scan_idx),
    .scan_q    (scan_data)
  );

  logic unused_top;
  assign unused_top = ^ram_scan_unused;

  always_comb begin
    unique case (region)
      RGN_RAM: cpu_rdata = ram_rd;
      RGN_SCR: cpu_rdata = scr_rd;
      RGN_KEY: cpu_rdata = key_code;
      default: cpu_rdata = '0;
    endcase
  end

  AST_KEY_READ: assert property (@(posedge clk) disable iff (rst)
    (cpu_addr == KEY_ADDR) |-> (cpu_rdata == key_code)); // R3

  AST_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
    (cpu_addr > KEY_ADDR) |-> (cpu_rdata == '0)); // R5

  AST_RMW_WRITEBACK: assert property (@(posedge clk) disable iff (rst)
    ($past(cpu_we) && ($past(cpu_addr) < KEY_ADDR) && (cpu_addr == $past(cpu_addr)))
      |-> (cpu_rdata == $past(cpu_wdata))); // R6

  initial begin
    AST_ROW_POW2: assert (ROW_WORDS == 2 ** COL_W);
  end

endmodule

// File: tb/data_mem_map_bench.sv
module data_mem_map_bench;

  localparam int RAM_AW = 9;
  localparam int SCR_AW = 8;
  localparam int ROW_WORDS = 32;
  localparam int COL_W = 5;
  localparam int ROW_W = SCR_AW - COL_W;
  localparam int SCR_BASE = 2 ** RAM_AW;
  localparam int KEY_A = SCR_BASE + 2 ** SCR_AW;
  localparam int SPACE = 2 ** (RAM_AW + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [RAM_AW:0] cpu_addr = '0;
  logic [15:0] cpu_wdata = '0;
  logic cpu_we = 1'b0;
  logic [15:0] cpu_rdata;
  logic [15:0] key_code = '0;
  logic [ROW_W-1:0] scan_row = '0;
  logic [COL_W-1:0] scan_col = '0;
  logic [15:0] scan_data;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  data_mem_map #(.RAM_AW(RAM_AW), .SCR_AW(SCR_AW), .ROW_WORDS(ROW_WORDS), .DATA_W(16))
  u_data_mem_map (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_we(cpu_we),
    .cpu_rdata(cpu_rdata), .key_code(key_code), .scan_row(scan_row), .scan_col(scan_col),
    .scan_data(scan_data)
  );

  function automatic logic [15:0] pat(int a);
    return 16'(a * 40503) ^ 16'hA5C3;
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 check("R9 reset", scan_data, 16'h0000);
    rst = 1'b0;

    // Fill every address, including the key word and the unused range (R4).
    for (int a = 0; a < SPACE; a++) begin
      @(negedge clk);
      cpu_addr = (RAM_AW + 1)'(a);
      cpu_wdata = pat(a);
      cpu_we = 1'b1;
    end
    @(negedge clk);
    cpu_we = 1'b0;
    key_code = 16'h0000;

    // Readback sweep: R1, R2, R10 contents; R3 idle key; R4, R5.
    for (int a = 0; a < SPACE; a++) begin
      cpu_addr = (RAM_AW + 1)'(a);
      #1;
      if (a < SCR_BASE)   check("R1/R10 ram", cpu_rdata, pat(a));
      else if (a < KEY_A) check("R2/R10 screen", cpu_rdata, pat(a));
      else if (a == KEY_A) check("R3/R4 key idle", cpu_rdata, 16'h0000);
      else                check("R5 above key", cpu_rdata, 16'h0000);
    end

    // Key word follows key_code combinationally (R3).
    cpu_addr = (RAM_AW + 1)'(KEY_A);
    key_code = 16'h0041; #1 check("R3 key", cpu_rdata, 16'h0041);
    key_code = 16'h008C; #1 check("R3 key", cpu_rdata, 16'h008C);
    key_code = 16'h0000; #1 check("R3 key release", cpu_rdata, 16'h0000);

    // Read-modify-write in one cycle on RAM and screen (R6).
    for (int k = 0; k < 2; k++) begin
      automatic int a = (k == 0) ? 100 : SCR_BASE + 77;
      @(negedge clk);
      cpu_addr = (RAM_AW + 1)'(a);
      #1 check("R6 old during write", cpu_rdata, pat(a));
      cpu_wdata = cpu_rdata + 16'd1;
      cpu_we = 1'b1;
      @(negedge clk);
      cpu_we = 1'b0;
      #1 check("R6 new after edge", cpu_rdata, pat(a) + 16'd1);
    end

    // Scanner sweep over all rows and columns (R7).
    for (int r = 0; r < 2 ** ROW_W; r++) begin
      for (int c = 0; c < ROW_WORDS; c++) begin
        automatic int off = r * ROW_WORDS + c;
        automatic logic [15:0] e = pat(SCR_BASE + off) + ((off == 77) ? 16'd1 : 16'd0);
        @(negedge clk);
        scan_row = ROW_W'(r);
        scan_col = COL_W'(c);
        @(negedge clk);
        #1 check("R7 scan word", scan_data, e);
      end
    end

    // Collision: CPU writes the word under the scanner (R8).
    @(negedge clk);
    scan_row = 3'd2;
    scan_col = 5'd3;
    cpu_addr = (RAM_AW + 1)'(SCR_BASE + 67);
    cpu_wdata = 16'hBEEF;
    cpu_we = 1'b1;
    @(negedge clk);
    cpu_we = 1'b0;
    #1 check("R8 old on write edge", scan_data, pat(SCR_BASE + 67));
    @(negedge clk);
    #1 check("R8 new next edge", scan_data, 16'hBEEF);

    // Reset clears scan output again (R9).
    rst = 1'b1;
    @(negedge clk);
    #1 check("R9 reset clear", scan_data, 16'h0000);
    rst = 1'b0;

    finish_run();
  end

endmodule